// File: doc/BRIEF.md
# Destination Address Screen for Ethernet Receive

This block decides whether an incoming Ethernet frame is kept, judging only by its 48-bit destination address. Address bits enter on one data port in the order they come off the wire. In serial mode a beat carries one bit. In byte mode a beat carries eight bits, with bit 0 of the port being the earliest bit on the wire. The two kinds of beat may be mixed within one frame. A start-of-frame strobe opens a frame. An end-of-frame strobe closes it early if the address was never completed.

Once 48 address bits have arrived, the block compares the address with a programmable station address. It also classifies the address as broadcast (all ones) or group (first wire bit set, not all ones). It then combines these results under three enables: take broadcast, take group addresses, and take everything. The verdict and a group-address flag are registered, held until the next start of frame, and passed to the receive logic that follows. That logic decides whether the frame is stored.

Top module: `rx_da_screen`

## Requirements
- R1: Wire bit n of the destination address (n = 0 to 47, counted from the first bit received) is compared with `station_addr[n]`, so `station_addr[7:0]` is the first byte on the wire, least significant bit first.
- R2: A received address equal to `station_addr` in all 48 bits is accepted whatever the enables; an address differing in any single bit is not accepted on that ground.
- R3: An all-ones address is accepted when `cfg_accept_bcast` is 1 and rejected when it is 0 (unless `cfg_promisc` is 1), and it never raises `mcast_seen`.
- R4: An address whose wire bit 0 is 1 and that is not all ones is a group address, accepted when `cfg_accept_mcast` is 1 and otherwise rejected (unless it matches or `cfg_promisc` is 1).
- R5: With `cfg_promisc` at 1, every frame that delivers 48 address bits is accepted.
- R6: `mcast_seen` is 1 exactly when the frame is accepted and its address is a group address that is not all ones.
- R7: A beat with `byte_mode` 0 carries one bit on `din[0]`. A beat with `byte_mode` 1 carries eight bits, `din[0]` first. Bits past the 48th are discarded, and both beat kinds may be mixed in a frame.
- R8: The verdict appears on `decision_valid`, `frame_accept` and `mcast_seen` in the cycle after the clock edge that takes the beat completing bit 47. It then holds until a start-of-frame, whose edge clears all three to 0.
- R9: If `eof` arrives while the frame is open and before 48 bits (including `sof` and `eof` in the same cycle), the next cycle shows `decision_valid` 1, `frame_accept` 0 and `mcast_seen` 0.
- R10: Beats arriving after a verdict or after an early `eof` are ignored until the next `sof`. A beat in the same cycle as `sof` is the first beat of the new frame.
- R11: Reset drives `decision_valid`, `frame_accept` and `mcast_seen` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start of frame, one cycle |
| eof | input | 1 | End of frame, one cycle |
| beat_valid | input | 1 | `din` carries address bits this cycle |
| byte_mode | input | 1 | 1: eight bits per beat, 0: one bit per beat |
| din | input | 8 | Address bits, `din[0]` earliest on the wire |
| station_addr | input | 48 | Station address, bit n matches wire bit n |
| cfg_accept_bcast | input | 1 | Accept the all-ones address |
| cfg_accept_mcast | input | 1 | Accept group addresses |
| cfg_promisc | input | 1 | Accept every complete address |
| decision_valid | output | 1 | Verdict available for the current frame |
| frame_accept | output | 1 | Frame is accepted |
| mcast_seen | output | 1 | Accepted frame carried a group address |

## Verification
The hardest cases to reach are near-misses. Random addresses almost never equal the station address or the all-ones value within one bit, so the mismatch paths for R2 and R3 would go untested. The stimulus therefore draws addresses from weighted classes: exact station copy, single-bit flips of the station address or of all ones, random group, random individual and broadcast. Each class is sent in serial, byte and randomly mixed beat patterns, sometimes with trailing junk bits past bit 47. Directed frames cover early end of frame, `sof` together with `eof`, and a truncated station match that is later completed without a new `sof`, which must stay rejected.

// File: rtl/rx_da_screen_pkg.sv
package rx_da_screen_pkg;

  // Aggregate filter: exact match, broadcast, group, or take-all.
  function automatic logic screen_verdict(input logic exact, input logic all_ones,
                                          input logic group_bit, input logic en_bc,
                                          input logic en_mc, input logic en_all);
    logic is_group;
    is_group = group_bit & ~all_ones;
    return exact | (all_ones & en_bc) | (is_group & en_mc) | en_all;
  endfunction

  // Group flag reported only for accepted non-broadcast group addresses.
  function automatic logic group_flag(input logic accepted, input logic all_ones,
                                      input logic group_bit);
    return accepted & group_bit & ~all_ones;
  endfunction

endpackage

// File: rtl/rx_da_lane.sv
module rx_da_lane #(
  parameter int ADDR_BITS = 48,
  parameter int CNT_W     = 6,
  parameter int LANE      = 0
) (
  input  logic                 lane_en,
  input  logic [CNT_W-1:0]     base_cnt,
  input  logic                 bit_in,
  input  logic [ADDR_BITS-1:0] station_addr,
  output logic                 hit,
  output logic                 one
);
  logic [CNT_W:0]         pos;
  logic                   in_range;
  logic [ADDR_BITS-1:0]   shifted;

  always_comb begin
    pos      = {1'b0, base_cnt} + (CNT_W+1)'(LANE);
    in_range = lane_en && (pos < (CNT_W+1)'(ADDR_BITS));
    shifted  = station_addr >> pos;
    hit      = ~in_range | (bit_in == shifted[0]);
    one      = ~in_range | bit_in;
  end
endmodule

// File: rtl/rx_da_verdict.sv
module rx_da_verdict
  import rx_da_screen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic full_now,
  input  logic short_end,
  input  logic match_n,
  input  logic ones_n,
  input  logic group_n,
  input  logic cfg_accept_bcast,
  input  logic cfg_accept_mcast,
  input  logic cfg_promisc,
  output logic decision_valid,
  output logic frame_accept,
  output logic mcast_seen
);
  logic acc_n;

  always_comb acc_n = screen_verdict(match_n, ones_n, group_n,
                                     cfg_accept_bcast, cfg_accept_mcast, cfg_promisc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_valid <= 1'b0;
      frame_accept   <= 1'b0;
      mcast_seen     <= 1'b0;
    end else if (full_now) begin
      decision_valid <= 1'b1;
      frame_accept   <= acc_n;
      mcast_seen     <= group_flag(acc_n, ones_n, group_n);
    end else if (short_end) begin
      decision_valid <= 1'b1;
      frame_accept   <= 1'b0;
      mcast_seen     <= 1'b0;
    end else if (sof) begin
      decision_valid <= 1'b0;
      frame_accept   <= 1'b0;
      mcast_seen     <= 1'b0;
    end
  end

  assert_accept_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> decision_valid);
  assert_group_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcast_seen |-> frame_accept);
  assert_take_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_now && cfg_promisc) |=> frame_accept);
  assert_short_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_end && !full_now) |=> (decision_valid && !frame_accept && !mcast_seen));
  assert_bcast_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_now && ones_n && !cfg_accept_bcast && !cfg_promisc && !match_n) |=> !frame_accept);
endmodule

// File: rtl/rx_da_screen.sv
module rx_da_screen #(
  parameter int ADDR_BITS = 48,
  parameter int BEAT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof,
  input  logic                 eof,
  input  logic                 beat_valid,
  input  logic                 byte_mode,
  input  logic [BEAT_W-1:0]    din,
  input  logic [ADDR_BITS-1:0] station_addr,
  input  logic                 cfg_accept_bcast,
  input  logic                 cfg_accept_mcast,
  input  logic                 cfg_promisc,
  output logic                 decision_valid,
  output logic                 frame_accept,
  output logic                 mcast_seen
);
  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q, base_cnt, cnt_n;
  logic [SUM_W-1:0]  sum;
  logic              open_q, base_open, take;
  logic              match_q, ones_q, group_q;
  logic              base_match, base_ones, base_group;
  logic              match_n, ones_n, group_n;
  logic              full_now, short_end;
  logic [BEAT_W-1:0] lane_en, lane_hit, lane_one;

  always_comb begin
    base_open  = sof | open_q;
    base_cnt   = sof ? '0 : cnt_q;
    base_match = sof | match_q;
    base_ones  = sof | ones_q;
    base_group = sof ? 1'b0 : group_q;
    take       = beat_valid & base_open;
  end

  genvar k;
  generate
    for (k = 0; k < BEAT_W; k++) begin : g_lane
      if (k == 0) begin : g_first
        assign lane_en[k] = take;
      end else begin : g_rest
        assign lane_en[k] = take & byte_mode;
      end
      rx_da_lane #(.ADDR_BITS(ADDR_BITS), .CNT_W(CNT_W), .LANE(k)) lane_i (
        .lane_en      (lane_en[k]),
        .base_cnt     (base_cnt),
        .bit_in       (din[k]),
        .station_addr (station_addr),
        .hit          (lane_hit[k]),
        .one          (lane_one[k])
      );
    end
  endgenerate

  always_comb begin
    sum = {1'b0, base_cnt};
    if (take) sum = sum + (byte_mode ? SUM_W'(BEAT_W) : SUM_W'(1));
    cnt_n     = (sum >= SUM_W'(ADDR_BITS)) ? CNT_W'(ADDR_BITS) : sum[CNT_W-1:0];
    match_n   = base_match & (&lane_hit);
    ones_n    = base_ones & (&lane_one);
    group_n   = (take && base_cnt == '0) ? din[0] : base_group;
    full_now  = take && (cnt_n == CNT_W'(ADDR_BITS));
    short_end = eof && base_open && !full_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      open_q  <= 1'b0;
      match_q <= 1'b1;
      ones_q  <= 1'b1;
      group_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      open_q  <= base_open & ~(full_now | short_end);
      match_q <= match_n;
      ones_q  <= ones_n;
      group_q <= group_n;
    end
  end

  rx_da_verdict verdict_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .sof              (sof),
    .full_now         (full_now),
    .short_end        (short_end),
    .match_n          (match_n),
    .ones_n           (ones_n),
    .group_n          (group_n),
    .cfg_accept_bcast (cfg_accept_bcast),
    .cfg_accept_mcast (cfg_accept_mcast),
    .cfg_promisc      (cfg_promisc),
    .decision_valid   (decision_valid),
    .frame_accept     (frame_accept),
    .mcast_seen       (mcast_seen)
  );

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !sof) |=> (decision_valid && $stable(frame_accept) && $stable(mcast_seen)));
  assert_sof_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !eof) |=> !decision_valid);
  assert_closed_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !open_q) |=> $stable(cnt_q));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BITS));
endmodule

// File: tb/rx_da_screen_tb_top.sv
module rx_da_screen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 0, eof = 0, beat_valid = 0, byte_mode = 0;
  logic [7:0]  din = '0;
  logic [47:0] station_addr = 48'h0;
  logic        cfg_accept_bcast = 0, cfg_accept_mcast = 0, cfg_promisc = 0;
  logic        decision_valid, frame_accept, mcast_seen;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  rx_da_screen dut_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .beat_valid(beat_valid),
    .byte_mode(byte_mode), .din(din), .station_addr(station_addr),
    .cfg_accept_bcast(cfg_accept_bcast), .cfg_accept_mcast(cfg_accept_mcast),
    .cfg_promisc(cfg_promisc), .decision_valid(decision_valid),
    .frame_accept(frame_accept), .mcast_seen(mcast_seen)
  );

  function automatic bit exp_accept(input logic [47:0] a);
    bit bc = (a == {48{1'b1}});
    return (a == station_addr) || (bc && cfg_accept_bcast) ||
           (a[0] && !bc && cfg_accept_mcast) || cfg_promisc;
  endfunction

  function automatic bit exp_group(input logic [47:0] a);
    return exp_accept(a) && a[0] && (a != {48{1'b1}});
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // mode 0 serial, 1 bytes, 2 mixed; nbits bits of stream sent (bits past 47 are junk)
  task automatic send(input logic [47:0] a, input int mode, input int nbits, input bit with_eof);
    logic [63:0] stream;
    int pos;
    bit first;
    stream = {16'($urandom), a};
    pos = 0;
    first = 1;
    while (pos < nbits) begin
      @(negedge clk);
      sof = first;
      first = 0;
      beat_valid = 1;
      byte_mode = (mode == 1) || (mode == 2 && $urandom_range(0, 1) == 1);
      if (byte_mode && pos + 8 <= 64) din = stream[pos +: 8];
      else if (byte_mode) din = 8'($urandom);
      else din = {7'($urandom), stream[pos]};
      pos += byte_mode ? 8 : 1;
    end
    @(negedge clk);
    sof = first;
    beat_valid = 0;
    eof = with_eof;
    if (with_eof || first) begin
      @(negedge clk);
    end
    sof = 0;
    eof = 0;
  endtask

  task automatic check_frame(input string req, input logic [47:0] a);
    check({req, " valid"}, decision_valid, 1'b1);
    check({req, " accept"}, frame_accept, exp_accept(a));
    check({req, " group"}, mcast_seen, exp_group(a));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd1729));
    station_addr = 48'hBA98_7654_3210;
    #1;
    check("R11 valid", decision_valid, 1'b0);
    check("R11 accept", frame_accept, 1'b0);
    check("R11 group", mcast_seen, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1/R2: exact match serial and byte, near-miss at first and last bit
    send(station_addr, 0, 48, 0); check_frame("R1 serial exact", station_addr);
    send(station_addr, 1, 48, 0); check_frame("R7 byte exact", station_addr);
    send(station_addr ^ 48'h1, 0, 48, 0); check_frame("R2 miss bit0", station_addr ^ 48'h1);
    send(station_addr ^ (48'h1 << 47), 1, 48, 0); check_frame("R2 miss bit47", station_addr ^ (48'h1 << 47));
    // R3 broadcast gate
    send({48{1'b1}}, 1, 48, 0); check_frame("R3 bcast off", {48{1'b1}});
    cfg_accept_bcast = 1;
    send({48{1'b1}}, 0, 48, 0); check_frame("R3 bcast on", {48{1'b1}});
    cfg_accept_mcast = 1;
    send({48{1'b1}}, 2, 48, 0); check_frame("R3 bcast not group", {48{1'b1}});
    cfg_accept_bcast = 0;
    send({48{1'b1}}, 1, 48, 0); check_frame("R3 bcast with mcast only", {48{1'b1}});
    // R4/R6 group
    send(48'h0000_0000_0101, 1, 48, 0); check_frame("R4 group on", 48'h0000_0000_0101);
    cfg_accept_mcast = 0;
    send(48'h0000_0000_0101, 0, 48, 0); check_frame("R4 group off", 48'h0000_0000_0101);
    // R5 promiscuous
    cfg_promisc = 1;
    send(48'h1234_5678_9ABC, 2, 56, 0); check_frame("R5 take all", 48'h1234_5678_9ABC);
    send(48'h1234_5678_9ABD, 1, 48, 0); check_frame("R5 group via all R6", 48'h1234_5678_9ABD);
    cfg_promisc = 0;

    // R8 hold then sof clears
    send(station_addr, 1, 48, 0);
    repeat (4) @(negedge clk);
    check("R8 hold valid", decision_valid, 1'b1);
    check("R8 hold accept", frame_accept, 1'b1);
    sof = 1; beat_valid = 1; byte_mode = 1; din = station_addr[7:0];
    @(negedge clk);
    sof = 0; beat_valid = 0;
    check("R8 sof clears valid", decision_valid, 1'b0);
    check("R8 sof clears accept", frame_accept, 1'b0);

    // R9 short frame, then R10 completion without sof is ignored
    send(station_addr, 1, 40, 1);
    check("R9 short valid", decision_valid, 1'b1);
    check("R9 short accept", frame_accept, 1'b0);
    @(negedge clk); beat_valid = 1; byte_mode = 1; din = station_addr[47:40];
    @(negedge clk); beat_valid = 0;
    @(negedge clk);
    check("R10 ignored after eof", frame_accept, 1'b0);
    check("R10 still valid", decision_valid, 1'b1);
    send(station_addr, 0, 0, 1);
    check("R9 sof with eof valid", decision_valid, 1'b1);
    check("R9 sof with eof accept", frame_accept, 1'b0);
    // R10 beats after decision: junk after a miss
    send(48'h0, 0, 48, 0);
    @(negedge clk); beat_valid = 1; byte_mode = 1; din = 8'hFF;
    @(negedge clk); beat_valid = 0; eof = 1;
    @(negedge clk); eof = 0;
    check("R10 late eof ignored valid", decision_valid, 1'b1);
    check("R10 late eof ignored accept", frame_accept, exp_accept(48'h0));

    // random classes
    for (int i = 0; i < 300; i++) begin
      int cls;
      cls = $urandom_range(0, 5);
      case (cls)
        0: a = station_addr;
        1: a = station_addr ^ (48'h1 << $urandom_range(0, 47));
        2: a = {48{1'b1}};
        3: a = {48{1'b1}} ^ (48'h1 << $urandom_range(1, 47));
        4: a = {16'($urandom), 32'($urandom)} | 48'h1;
        default: a = {16'($urandom), 32'($urandom)} & ~48'h1;
      endcase
      cfg_accept_bcast = 1'($urandom);
      cfg_accept_mcast = 1'($urandom);
      cfg_promisc      = ($urandom_range(0, 5) == 0);
      send(a, $urandom_range(0, 2), 48 + 8 * $urandom_range(0, 1), 0);
      check_frame("R1 R2 R3 R4 R6 R7 random", a);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule